// File: doc/BRIEF.md
# Checksummed serial frame receiver

This block sits behind a UART receiver and turns its byte stream into frames for a flash-programming link. Two frame kinds share the wire. A command frame carries a command code and its parameters. A data frame carries a block of data bytes. The first byte of a frame selects its kind. A length byte follows, then the payload, a checksum byte and a closing byte.

The receiver stores the payload in an internal buffer. It checks the checksum and the closing byte, then raises a one-cycle completion strobe. With the strobe it presents the frame kind, the payload length, a checksum-error flag, a format-error flag and a last-frame indication. Downstream logic reads the payload through a random-access read port. It can then answer the sender, for example with status 0x07 when the checksum flag is set.

A programmable inter-byte timeout abandons a frame that stalls part way through. This keeps the receiver aligned when the sender gives up on a frame.

Top module: `frame_rx`

## Requirements
- R1: While idle, byte 0x01 starts a command frame and byte 0x02 starts a data frame. With the completion strobe, `frm_type` is 0 for a command frame and 1 for a data frame.
- R2: While idle, any byte other than 0x01 or 0x02 is dropped. It raises no strobe and no flag, and the next valid frame is received normally.
- R3: The byte after the header is the payload length, where 0x00 means 256. `pay_len` reports this length. In a command frame the payload counts the command code plus its parameters, so payload byte 0 is the command code.
- R4: After the strobe, `rd_data` returns payload byte `rd_addr` for `rd_addr` from 0 to length-1, in arrival order.
- R5: The expected checksum is 0x00 minus the length byte minus every payload byte, modulo 256. `sum_err` is 1 with the strobe when the received checksum byte differs from it, and 0 otherwise.
- R6: A command frame must close with 0x03. A data frame may close with 0x03 (last frame) or 0x17 (more frames follow). Any other closing byte sets `fmt_err` to 1 with the strobe. `frm_last` is 0 only for a data frame closed with 0x17.
- R7: `done` is high for exactly one cycle, in the cycle after the closing byte is accepted. `frm_type`, `pay_len`, `frm_last`, `sum_err` and `fmt_err` hold their values until the next strobe.
- R8: Inside a frame, if `timeout_cycles` (T, nonzero) consecutive cycles pass with no byte, the frame is abandoned without a strobe and the receiver returns to idle. A T of 0 disables the timeout.
- R9: A byte that arrives after exactly T-1 byteless cycles is still accepted, and the frame continues.
- R10: After reset, `done`, `sum_err`, `fmt_err` and `pay_len` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_data | input | 8 | Received byte |
| timeout_cycles | input | TMO_W | Inter-byte timeout in cycles, 0 disables it |
| done | output | 1 | One-cycle frame-complete strobe |
| frm_type | output | 1 | 0 command frame, 1 data frame |
| frm_last | output | 1 | 0 when a data frame announced more frames |
| pay_len | output | 9 | Payload length, 1 to 256 |
| rd_addr | input | 8 | Payload read address |
| rd_data | output | 8 | Payload byte at rd_addr |
| sum_err | output | 1 | Checksum mismatch |
| fmt_err | output | 1 | Bad closing byte |

## Verification
The timeout expiry and the arrival of a byte can fall in the same cycle. This happens when a byte lands after exactly T-1 byteless cycles, and the byte must win. The bench stalls a frame for T-1 cycles in one run and for T cycles in another, then sends the rest of the frame or a fresh frame. It judges the outcome only at the ports: a correct strobe and payload, or a missing one. It also mixes random idle garbage between random frames. This shows that header detection and discarding never collide with the end of a frame.

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic [TMO_W-1:0] timeout_cycles,
  output logic             done,
  output logic             frm_type,
  output logic             frm_last,
  output logic [8:0]       pay_len,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             sum_err,
  output logic             fmt_err
);
  localparam int DEPTH = 256;
  localparam logic [7:0] HDR_CMD = 8'h01;
  localparam logic [7:0] HDR_DAT = 8'h02;
  localparam logic [7:0] END_LAST = 8'h03;
  localparam logic [7:0] END_MORE = 8'h17;

  typedef enum logic [2:0] {S_IDLE, S_LEN, S_PAY, S_SUM, S_END} st_t;

  st_t              st;
  logic             typ;
  logic [8:0]       len_q;
  logic [8:0]       cnt;
  logic [7:0]       acc;
  logic             sum_ok;
  logic [TMO_W-1:0] tmo;
  logic [7:0]       mem [DEPTH];

  wire tmo_hit = (st != S_IDLE) && !in_valid && (timeout_cycles != '0) &&
                 (tmo == timeout_cycles - 1'b1);
  wire end_ok  = (in_data == END_LAST) || (typ && in_data == END_MORE);

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk)
    if (in_valid && st == S_PAY) mem[cnt[7:0]] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      typ <= 1'b0;
      len_q <= '0;
      cnt <= '0;
      acc <= '0;
      sum_ok <= 1'b0;
      tmo <= '0;
      done <= 1'b0;
      frm_type <= 1'b0;
      frm_last <= 1'b0;
      pay_len <= '0;
      sum_err <= 1'b0;
      fmt_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_valid || st == S_IDLE) tmo <= '0;
      else if (tmo_hit) begin
        tmo <= '0;
        st <= S_IDLE;
      end else tmo <= tmo + 1'b1;
      if (in_valid) begin
        case (st)
          S_IDLE:
            if (in_data == HDR_CMD || in_data == HDR_DAT) begin
              typ <= (in_data == HDR_DAT);
              st <= S_LEN;
            end
          S_LEN: begin
            len_q <= (in_data == 8'h00) ? 9'(DEPTH) : {1'b0, in_data};
            acc <= 8'h00 - in_data;
            cnt <= '0;
            st <= S_PAY;
          end
          S_PAY: begin
            acc <= acc - in_data;
            cnt <= cnt + 1'b1;
            if (cnt == len_q - 1'b1) st <= S_SUM;
          end
          S_SUM: begin
            sum_ok <= (in_data == acc);
            st <= S_END;
          end
          S_END: begin
            done <= 1'b1;
            frm_type <= typ;
            pay_len <= len_q;
            sum_err <= !sum_ok;
            fmt_err <= !end_ok;
            frm_last <= !(typ && in_data == END_MORE);
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid));
  assert_len_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pay_len != 9'd0);
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PAY |-> cnt < len_q);
  assert_discard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && in_valid && in_data != HDR_CMD && in_data != HDR_DAT) |=> st == S_IDLE && !done);
  assert_flags_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sum_err) && $stable(fmt_err) && $stable(pay_len));
  assert_cmd_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !frm_type) |-> frm_last);
endmodule

// File: tb/sim_frame_rx.sv
module sim_frame_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [15:0] timeout_cycles = 16'd6;
  logic [7:0] rd_addr = 8'h00;
  logic done, frm_type, frm_last, sum_err, fmt_err;
  logic [8:0] pay_len;
  logic [7:0] rd_data;
  int checks = 0;
  int errors = 0;
  logic [7:0] pay [256];

  always #10 clk = ~clk;

  frame_rx #(.TMO_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .timeout_cycles(timeout_cycles), .done(done), .frm_type(frm_type),
    .frm_last(frm_last), .pay_len(pay_len), .rd_addr(rd_addr),
    .rd_data(rd_data), .sum_err(sum_err), .fmt_err(fmt_err));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_sum(input logic [7:0] lb);
    int n = (lb == 8'h00) ? 256 : int'(lb);
    logic [7:0] s = 8'h00 - lb;
    for (int i = 0; i < n; i++) s = s - pay[i];
    return s;
  endfunction

  task automatic send_body(input bit dat, input logic [7:0] lb, input bit bad_sum,
                           input logic [7:0] foot, input int from);
    int n = (lb == 8'h00) ? 256 : int'(lb);
    logic [7:0] s = exp_sum(lb);
    if (from == 0) begin
      put(dat ? 8'h02 : 8'h01);
      put(lb);
    end
    for (int i = from; i < n; i++) put(pay[i]);
    put(bad_sum ? (s ^ 8'h5A) : s);
    put(foot);
  endtask

  task automatic judge(input bit dat, input logic [7:0] lb, input bit bad_sum,
                       input logic [7:0] foot);
    int n = (lb == 8'h00) ? 256 : int'(lb);
    bit efmt = !(foot == 8'h03 || (dat && foot == 8'h17));
    bit elast = !(dat && foot == 8'h17);
    int bad = 0;
    check(done == 1'b1, "R7 done after footer", int'(done), 1);
    check(frm_type == dat, "R1 frame type", int'(frm_type), int'(dat));
    check(pay_len == 9'(n), "R3 payload length", int'(pay_len), n);
    check(sum_err == bad_sum, "R5 checksum flag", int'(sum_err), int'(bad_sum));
    check(fmt_err == efmt, "R6 format flag", int'(fmt_err), int'(efmt));
    check(frm_last == elast, "R6 last flag", int'(frm_last), int'(elast));
    @(negedge clk);
    check(done == 1'b0, "R7 single-cycle strobe", int'(done), 0);
    check(pay_len == 9'(n) && sum_err == bad_sum && fmt_err == efmt,
          "R7 results held", int'(pay_len), n);
    for (int i = 0; i < n; i++) begin
      rd_addr = 8'(i);
      #1;
      if (rd_data !== pay[i]) bad++;
    end
    check(bad == 0, "R4 payload readback mismatches", bad, 0);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle(3);
    check(done == 0 && sum_err == 0 && fmt_err == 0 && pay_len == 0,
          "R10 reset state", int'(pay_len), 0);
    rst_n = 1'b1;
    idle(2);

    fill(3);
    pay[0] = 8'h40;
    send_body(1'b0, 8'd3, 1'b0, 8'h03, 0);
    judge(1'b0, 8'd3, 1'b0, 8'h03);
    check(pay[0] == 8'h40, "R3 command code is payload byte 0", int'(pay[0]), 'h40);

    fill(256);
    send_body(1'b1, 8'h00, 1'b0, 8'h17, 0);
    judge(1'b1, 8'h00, 1'b0, 8'h17);

    fill(5);
    send_body(1'b1, 8'd5, 1'b1, 8'h03, 0);
    judge(1'b1, 8'd5, 1'b1, 8'h03);

    fill(2);
    send_body(1'b0, 8'd2, 1'b0, 8'h17, 0);
    judge(1'b0, 8'd2, 1'b0, 8'h17);

    fill(4);
    send_body(1'b1, 8'd4, 1'b0, 8'h55, 0);
    judge(1'b1, 8'd4, 1'b0, 8'h55);

    for (int g = 0; g < 6; g++) begin
      logic [7:0] b;
      do b = 8'($urandom); while (b == 8'h01 || b == 8'h02);
      put(b);
      check(done == 1'b0, "R2 idle garbage raises no strobe", int'(done), 0);
    end
    fill(1);
    send_body(1'b0, 8'd1, 1'b0, 8'h03, 0);
    judge(1'b0, 8'd1, 1'b0, 8'h03);

    // R8: a stall of T byteless cycles abandons the frame
    fill(3);
    put(8'h01); put(8'd3); put(pay[0]);
    idle(5);
    fill(2);
    send_body(1'b0, 8'd2, 1'b0, 8'h03, 0);
    judge(1'b0, 8'd2, 1'b0, 8'h03);

    // R9: a byte after exactly T-1 byteless cycles is accepted
    fill(3);
    put(8'h02); put(8'd3); put(pay[0]);
    idle(4);
    send_body(1'b1, 8'd3, 1'b0, 8'h03, 1);
    judge(1'b1, 8'd3, 1'b0, 8'h03);

    // R8: zero disables the timeout
    timeout_cycles = 16'd0;
    fill(2);
    put(8'h01); put(8'd2); put(pay[0]);
    idle(60);
    send_body(1'b0, 8'd2, 1'b0, 8'h03, 1);
    judge(1'b0, 8'd2, 1'b0, 8'h03);
    timeout_cycles = 16'd6;

    for (int f = 0; f < 40; f++) begin
      bit dat = 1'($urandom);
      logic [7:0] lb = 8'($urandom_range(1, 24));
      bit bs = ($urandom_range(0, 4) == 0);
      int r = $urandom_range(0, 5);
      logic [7:0] ft = (r == 0) ? 8'h17 : (r == 1) ? 8'h7E : 8'h03;
      if ($urandom_range(0, 2) == 0) put(8'h99);
      fill(int'(lb));
      send_body(dat, lb, bs, ft, 0);
      judge(dat, lb, bs, ft);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule